// File: doc/BRIEF.md
# Data Memory Load/Store Unit

This block sits between a processor datapath and its data bus. The datapath presents one load or store at a time, with an address, an access width and, for stores, the data to write. The unit turns that into a single bus request. For stores it places the data in the correct byte lanes and generates byte strobes. For loads it picks the addressed byte or halfword out of the returned word and extends it to 32 bits, with sign or zero extension as requested.

Before anything reaches the bus, the address is checked against the access width. A misaligned access completes at once with a misaligned-address trap and never produces a request. A bus error reply becomes an access-fault trap, with different cause codes for loads and stores.

The datapath is told to stall from the cycle it presents the operation until the cycle the operation completes. It must hold every operation input steady while the stall is high. The request is driven straight from those held inputs, so no copy of the operation is kept inside the unit.

Top module: `lsu_core`

## Requirements
- R1: An aligned operation presented while the unit is idle drives `req_valid` in the same cycle. `req_addr`, `req_size` and `req_we` (1 for a store) are copied from the operation, and `req_amo` is 0. Size encoding: 2'b00 byte, 2'b01 halfword, 2'b10 word.
- R2: Store strobes are set as follows. A byte store uses 4'b0001 shifted left by addr[1:0]. A halfword store uses 4'b0011 when addr[1] is 0 and 4'b1100 when it is 1. A word store uses 4'b1111.
- R3: Store write data repeats the low byte in all four lanes for byte stores and the low halfword in both halves for halfword stores. Word stores pass the data through unchanged.
- R4: A load with `op_unsigned`=0 returns the addressed byte (lane addr[1:0]) or halfword (upper half when addr[1] is 1), sign-extended to 32 bits.
- R5: A load with `op_unsigned`=1 returns the addressed byte or halfword zero-extended. A word load returns the bus word unchanged, whatever `op_unsigned` is.
- R6: A misaligned load completes in its first cycle with `op_trap`=1 and `op_cause`=4, and issues no request. Misaligned means a halfword with addr[0]=1, or a word with addr[1:0] nonzero.
- R7: A misaligned store completes in its first cycle with `op_trap`=1 and `op_cause`=6, and issues no request.
- R8: A load whose response carries `rsp_err`=1 completes with `op_trap`=1 and `op_cause`=5.
- R9: A store whose response carries `rsp_err`=1 completes with `op_trap`=1 and `op_cause`=7.
- R10: `op_stall` is high in every cycle of an operation except the one with `op_done`=1. If the request is accepted at once and the reply comes one cycle later, an aligned access completes in its second cycle.
- R11: While `req_ready` is low, `req_valid` and the request fields stay steady. After a request is accepted, no new request is driven until its response has returned.
- R12: During and after reset, with no operation presented, `req_valid`, `rsp_ready`, `op_stall` and `op_done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Datapath presents an operation |
| op_store | input | 1 | 1 store, 0 load |
| op_size | input | 2 | Access width (00 byte, 01 half, 10 word) |
| op_unsigned | input | 1 | Load zero-extends when 1 |
| op_addr | input | ADDR_W | Byte address |
| op_wdata | input | 32 | Store data, right-aligned |
| op_stall | output | 1 | Datapath must hold |
| op_done | output | 1 | Operation completes this cycle |
| op_trap | output | 1 | Completion is a trap |
| op_cause | output | 4 | Trap cause code |
| op_rdata | output | 32 | Extended load result |
| req_valid | output | 1 | Bus request valid |
| req_ready | input | 1 | Bus accepts request |
| req_addr | output | ADDR_W | Request address |
| req_we | output | 1 | Request is a write |
| req_size | output | 2 | Request width |
| req_wdata | output | 32 | Lane-replicated write data |
| req_wstrb | output | 4 | Byte strobes |
| req_amo | output | AMO_W | Atomic op field, always 0 |
| rsp_valid | input | 1 | Bus response valid |
| rsp_ready | output | 1 | Unit accepts response |
| rsp_rdata | input | 32 | Read word |
| rsp_err | input | 1 | Slave access fault |

## Verification
The hardest case to reach from the ports is a request held under backpressure while a reply is still due, together with error replies on both loads and stores. A plain one-cycle memory never produces either. The bench memory model therefore takes a grant delay and an error flag for each access. The driver sets these per operation, so held requests, late grants and faulting replies all occur on ordinary loads and stores. Misaligned cases pair every width with every offset, and the bench watches that no request appears for any of them.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned LANES   = WORD_W / 8;
  localparam int unsigned LANE_AW = $clog2(LANES);
  localparam int unsigned CAUSE_W = 4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10
  } acc_size_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } lsu_state_e;

  localparam logic [CAUSE_W-1:0] CAUSE_LD_MISALIGN = 4'd4;
  localparam logic [CAUSE_W-1:0] CAUSE_LD_FAULT    = 4'd5;
  localparam logic [CAUSE_W-1:0] CAUSE_ST_MISALIGN = 4'd6;
  localparam logic [CAUSE_W-1:0] CAUSE_ST_FAULT    = 4'd7;

endpackage

// File: rtl/lsu_store_align.sv
module lsu_store_align
  import lsu_pkg::*;
(
  input  logic [1:0]         size,
  input  logic [LANE_AW-1:0] lane,
  input  logic [WORD_W-1:0]  data_in,
  output logic [LANES-1:0]   strb,
  output logic [WORD_W-1:0]  data_out
);

  always_comb begin
    case (size)
      SZ_BYTE: begin
        strb     = 4'b0001 << lane;
        data_out = {LANES{data_in[7:0]}};
      end
      SZ_HALF: begin
        strb     = 4'b0011 << {lane[1], 1'b0};
        data_out = {(LANES/2){data_in[15:0]}};
      end
      default: begin
        strb     = '1;
        data_out = data_in;
      end
    endcase
  end

endmodule

// File: rtl/lsu_load_extend.sv
module lsu_load_extend
  import lsu_pkg::*;
(
  input  logic [1:0]         size,
  input  logic [LANE_AW-1:0] lane,
  input  logic               zext,
  input  logic [WORD_W-1:0]  word_in,
  output logic [WORD_W-1:0]  data_out
);

  logic [7:0]  pick_b;
  logic [15:0] pick_h;
  logic        fill_b;
  logic        fill_h;

  always_comb begin
    case (lane)
      2'd0:    pick_b = word_in[7:0];
      2'd1:    pick_b = word_in[15:8];
      2'd2:    pick_b = word_in[23:16];
      default: pick_b = word_in[31:24];
    endcase
    pick_h = lane[1] ? word_in[31:16] : word_in[15:0];
    fill_b = ~zext & pick_b[7];
    fill_h = ~zext & pick_h[15];
  end

  always_comb begin
    case (size)
      SZ_BYTE: data_out = {{(WORD_W-8){fill_b}}, pick_b};
      SZ_HALF: data_out = {{(WORD_W-16){fill_h}}, pick_h};
      default: data_out = word_in;
    endcase
  end

endmodule

// File: rtl/lsu_cause_map.sv
module lsu_cause_map
  import lsu_pkg::*;
(
  input  logic [1:0]         size,
  input  logic [LANE_AW-1:0] lane,
  input  logic               is_store,
  output logic               misaligned,
  output logic [CAUSE_W-1:0] align_cause,
  output logic [CAUSE_W-1:0] bus_cause
);

  always_comb begin
    case (size)
      SZ_BYTE: misaligned = 1'b0;
      SZ_HALF: misaligned = lane[0];
      default: misaligned = |lane;
    endcase
    align_cause = is_store ? CAUSE_ST_MISALIGN : CAUSE_LD_MISALIGN;
    bus_cause   = is_store ? CAUSE_ST_FAULT    : CAUSE_LD_FAULT;
  end

endmodule

// File: rtl/lsu_core.sv
module lsu_core
  import lsu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned AMO_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic              op_store,
  input  logic [1:0]        op_size,
  input  logic              op_unsigned,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [31:0]       op_wdata,
  output logic              op_stall,
  output logic              op_done,
  output logic              op_trap,
  output logic [3:0]        op_cause,
  output logic [31:0]       op_rdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic              req_we,
  output logic [1:0]        req_size,
  output logic [31:0]       req_wdata,
  output logic [3:0]        req_wstrb,
  output logic [AMO_W-1:0]  req_amo,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [31:0]       rsp_rdata,
  input  logic              rsp_err
);

  lsu_state_e         state_q, state_d;
  logic               state_en;
  logic [LANE_AW-1:0] lane;
  logic               misaligned;
  logic [CAUSE_W-1:0] align_cause, bus_cause;
  logic               idle, issue, accept, resp_fire, align_fire;

  assign lane = op_addr[LANE_AW-1:0];

  lsu_cause_map u_cause (
    .size        (op_size),
    .lane        (lane),
    .is_store    (op_store),
    .misaligned  (misaligned),
    .align_cause (align_cause),
    .bus_cause   (bus_cause)
  );

  lsu_store_align u_store (
    .size     (op_size),
    .lane     (lane),
    .data_in  (op_wdata),
    .strb     (req_wstrb),
    .data_out (req_wdata)
  );

  lsu_load_extend u_load (
    .size     (op_size),
    .lane     (lane),
    .zext     (op_unsigned),
    .word_in  (rsp_rdata),
    .data_out (op_rdata)
  );

  // Issue and completion decode
  always_comb begin
    idle       = (state_q == ST_IDLE);
    issue      = idle && op_valid && !misaligned;
    accept     = issue && req_ready;
    align_fire = idle && op_valid && misaligned;
    resp_fire  = (state_q == ST_WAIT) && rsp_valid;
  end

  assign req_valid = issue;
  assign req_addr  = op_addr;
  assign req_we    = op_store;
  assign req_size  = op_size;
  assign req_amo   = '0;
  assign rsp_ready = (state_q == ST_WAIT);

  always_comb begin
    op_done  = align_fire || resp_fire;
    op_trap  = align_fire || (resp_fire && rsp_err);
    if (align_fire)                op_cause = align_cause;
    else if (resp_fire && rsp_err) op_cause = bus_cause;
    else                           op_cause = '0;
    op_stall = (!idle || op_valid) && !op_done;
  end

  // Next state
  always_comb begin
    state_d  = state_q;
    state_en = 1'b0;
    case (state_q)
      ST_IDLE: if (accept) begin
        state_d  = ST_WAIT;
        state_en = 1'b1;
      end
      default: if (resp_fire) begin
        state_d  = ST_IDLE;
        state_en = 1'b1;
      end
    endcase
  end

  // State register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= ST_IDLE;
    else if (state_en) state_q <= state_d;
  end

  // R6/R7: nothing misaligned ever reaches the bus
  p_req_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !((req_size == SZ_HALF) && req_addr[0])
               && !((req_size == SZ_WORD) && (req_addr[1:0] != 2'b00)));

  p_strobe_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_we) |->
      ($countones(req_wstrb) == ((req_size == SZ_BYTE) ? 1 :
                                 (req_size == SZ_HALF) ? 2 : 4)));

  p_hold_request_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_wstrb)));

  p_one_outstanding_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_valid);

  p_load_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready && rsp_err && !op_store) |-> (op_trap && op_cause == 4'd5));

  p_store_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready && rsp_err && op_store) |-> (op_trap && op_cause == 4'd7));

  p_done_frees_r10: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |-> !op_stall);

endmodule

// File: tb/lsu_core_tb_top.sv
`timescale 1ns/100ps
module lsu_core_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid, op_store, op_unsigned;
  logic [1:0]  op_size;
  logic [31:0] op_addr, op_wdata;
  logic        op_stall, op_done, op_trap;
  logic [3:0]  op_cause;
  logic [31:0] op_rdata;
  logic        req_valid, req_ready, req_we;
  logic [31:0] req_addr, req_wdata;
  logic [1:0]  req_size;
  logic [3:0]  req_wstrb, req_amo;
  logic        rsp_valid, rsp_ready, rsp_err;
  logic [31:0] rsp_rdata;

  always #2.5 clk = ~clk;

  lsu_core dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_store(op_store),
    .op_size(op_size), .op_unsigned(op_unsigned), .op_addr(op_addr),
    .op_wdata(op_wdata), .op_stall(op_stall), .op_done(op_done),
    .op_trap(op_trap), .op_cause(op_cause), .op_rdata(op_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_we(req_we), .req_size(req_size), .req_wdata(req_wdata),
    .req_wstrb(req_wstrb), .req_amo(req_amo), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Memory model with per-access grant delay and error flag
  logic [31:0] mem_word;
  logic        mem_err;
  int          gnt_delay;
  int          wait_cnt;

  assign req_ready = (wait_cnt >= gnt_delay);

  always @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
      wait_cnt  <= 0;
    end else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      if (req_valid && req_ready) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= mem_word;
        rsp_err   <= mem_err;
        wait_cnt  <= 0;
      end else if (req_valid) begin
        wait_cnt <= wait_cnt + 1;
      end
    end
  end

  // Scoreboard
  typedef struct {
    bit          trap;
    logic [3:0]  cause;
    logic [31:0] data;
    bit          is_load;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always @(negedge clk) begin : monitor
    exp_t e;
    #1;
    if (rst_n === 1'b1 && op_done === 1'b1) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R10", "done with empty scoreboard", 32'd1, 32'd0);
      end else begin
        e = sb_q.pop_front();
        check(op_trap == e.trap, e.tag, "trap flag", {31'd0, op_trap}, {31'd0, e.trap});
        if (e.trap)
          check(op_cause == e.cause, e.tag, "cause", {28'd0, op_cause}, {28'd0, e.cause});
        else if (e.is_load)
          check(op_rdata == e.data, e.tag, "load data", op_rdata, e.data);
      end
    end
  end

  // Expected-value functions from the requirements
  function automatic logic [3:0] x_strb(input logic [1:0] sz, input logic [31:0] a);
    case (sz)
      2'b00:   return 4'b0001 << a[1:0];
      2'b01:   return a[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] x_wdata(input logic [1:0] sz, input logic [31:0] d);
    case (sz)
      2'b00:   return {d[7:0], d[7:0], d[7:0], d[7:0]};
      2'b01:   return {d[15:0], d[15:0]};
      default: return d;
    endcase
  endfunction

  function automatic logic [31:0] x_load(input logic [1:0] sz, input logic [31:0] a,
                                         input logic u, input logic [31:0] w);
    logic [7:0]  b;
    logic [15:0] h;
    b = w[8*a[1:0] +: 8];
    h = a[1] ? w[31:16] : w[15:0];
    case (sz)
      2'b00:   return u ? {24'd0, b} : {{24{b[7]}}, b};
      2'b01:   return u ? {16'd0, h} : {{16{h[15]}}, h};
      default: return w;
    endcase
  endfunction

  // Driver: one operation, expected result pushed to scoreboard
  task automatic access(input logic st, input logic [1:0] sz, input logic u,
                        input logic [31:0] a, input logic [31:0] wd,
                        input logic [31:0] rd, input logic err, input int dly,
                        input string tag);
    exp_t e;
    bit   mis;
    bit   saw;
    int   cyc;
    mis       = (sz == 2'b01 && a[0]) || (sz == 2'b10 && a[1:0] != 2'b00);
    e.trap    = mis || err;
    e.cause   = mis ? (st ? 4'd6 : 4'd4) : (st ? 4'd7 : 4'd5);
    e.data    = x_load(sz, a, u, rd);
    e.is_load = !st;
    e.tag     = tag;
    sb_q.push_back(e);
    @(negedge clk);
    mem_word = rd; mem_err = err; gnt_delay = dly;
    op_store = st; op_size = sz; op_unsigned = u; op_addr = a; op_wdata = wd;
    op_valid = 1'b1;
    cyc = 0;
    saw = 1'b0;
    forever begin
      #1;
      if (req_valid) begin
        saw = 1'b1;
        check(req_addr == a && req_we == st && req_size == sz, "R1", "request fields",
              req_addr, a);
        check(req_amo == 4'd0, "R1", "amo field", {28'd0, req_amo}, 32'd0);
        if (st) begin
          check(req_wstrb == x_strb(sz, a), "R2", "strobes",
                {28'd0, req_wstrb}, {28'd0, x_strb(sz, a)});
          check(req_wdata == x_wdata(sz, wd), "R3", "write data",
                req_wdata, x_wdata(sz, wd));
        end
      end
      if (op_done || cyc > 40) break;
      check(op_stall == 1'b1, "R10", "stall while pending", {31'd0, op_stall}, 32'd1);
      @(negedge clk);
      cyc++;
    end
    check(op_stall == 1'b0, "R10", "stall released at done", {31'd0, op_stall}, 32'd0);
    check(saw == !mis, mis ? (st ? "R7" : "R6") : "R1", "request issued",
          {31'd0, saw}, {31'd0, !mis});
    check(cyc == (mis ? 0 : dly + 1), dly > 0 ? "R11" : "R10", "completion cycle",
          cyc, mis ? 0 : dly + 1);
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  // Watchdog
  int cycle_cnt = 0;
  always @(posedge clk) begin
    cycle_cnt++;
    if (cycle_cnt > 20000 && !finished) begin
      finished = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycle_cnt);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    op_valid = 1'b0; op_store = 1'b0; op_size = 2'b00; op_unsigned = 1'b0;
    op_addr = '0; op_wdata = '0;
    mem_word = '0; mem_err = 1'b0; gnt_delay = 0;
    repeat (3) @(negedge clk);
    #1;
    check(req_valid == 0 && rsp_ready == 0 && op_stall == 0 && op_done == 0,
          "R12", "outputs in reset", {28'd0, req_valid, rsp_ready, op_stall, op_done}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    check(req_valid == 0 && rsp_ready == 0 && op_stall == 0 && op_done == 0,
          "R12", "outputs after reset", {28'd0, req_valid, rsp_ready, op_stall, op_done}, 32'd0);

    // R2 R3: stores at every aligned lane
    for (int k = 0; k < 4; k++)
      access(1'b1, 2'b00, 1'b0, 32'h8000_0100 + k, 32'h1234_56A5, 32'h0, 1'b0, 0, "R2");
    access(1'b1, 2'b01, 1'b0, 32'h8000_0200, 32'hDEAD_BEEF, 32'h0, 1'b0, 0, "R3");
    access(1'b1, 2'b01, 1'b0, 32'h8000_0202, 32'h0BAD_C0DE, 32'h0, 1'b0, 0, "R3");
    access(1'b1, 2'b10, 1'b0, 32'h8000_0204, 32'hCAFE_F00D, 32'h0, 1'b0, 0, "R2");

    // R4 R5: loads in every lane, both extensions
    for (int k = 0; k < 4; k++) begin
      access(1'b0, 2'b00, 1'b0, 32'h8000_0300 + k, 32'h0, 32'h80FF_7F01, 1'b0, 0, "R4");
      access(1'b0, 2'b00, 1'b1, 32'h8000_0300 + k, 32'h0, 32'h80FF_7F01, 1'b0, 0, "R5");
    end
    access(1'b0, 2'b01, 1'b0, 32'h8000_0400, 32'h0, 32'h7FFF_8001, 1'b0, 0, "R4");
    access(1'b0, 2'b01, 1'b0, 32'h8000_0402, 32'h0, 32'h9234_0001, 1'b0, 0, "R4");
    access(1'b0, 2'b01, 1'b1, 32'h8000_0400, 32'h0, 32'h7FFF_8001, 1'b0, 0, "R5");
    access(1'b0, 2'b01, 1'b1, 32'h8000_0402, 32'h0, 32'h9234_0001, 1'b0, 0, "R5");
    access(1'b0, 2'b10, 1'b0, 32'h8000_0404, 32'h0, 32'hF0E1_D2C3, 1'b0, 0, "R5");
    access(1'b0, 2'b10, 1'b1, 32'h8000_0408, 32'h0, 32'h8765_4321, 1'b0, 0, "R5");

    // R6 R7: every misaligned offset
    access(1'b0, 2'b01, 1'b0, 32'h8000_0501, 32'h0, 32'h0, 1'b0, 0, "R6");
    access(1'b0, 2'b01, 1'b1, 32'h8000_0503, 32'h0, 32'h0, 1'b0, 0, "R6");
    for (int k = 1; k < 4; k++) begin
      access(1'b0, 2'b10, 1'b0, 32'h8000_0600 + k, 32'h0, 32'h0, 1'b0, 0, "R6");
      access(1'b1, 2'b10, 1'b0, 32'h8000_0700 + k, 32'h1111_2222, 32'h0, 1'b0, 0, "R7");
    end
    access(1'b1, 2'b01, 1'b0, 32'h8000_0801, 32'h3333_4444, 32'h0, 1'b0, 0, "R7");
    access(1'b1, 2'b01, 1'b0, 32'h8000_0803, 32'h3333_4444, 32'h0, 1'b0, 0, "R7");

    // R8 R9: bus errors
    access(1'b0, 2'b10, 1'b0, 32'h1000_0F00, 32'h0, 32'h5555_AAAA, 1'b1, 0, "R8");
    access(1'b0, 2'b00, 1'b1, 32'h1000_0F03, 32'h0, 32'h5555_AAAA, 1'b1, 2, "R8");
    access(1'b1, 2'b10, 1'b0, 32'h1000_0F04, 32'h7777_8888, 32'h0, 1'b1, 0, "R9");
    access(1'b1, 2'b01, 1'b0, 32'h1000_0F06, 32'h7777_8888, 32'h0, 1'b1, 1, "R9");

    // R11: backpressure on loads and stores
    access(1'b0, 2'b01, 1'b0, 32'h8000_0902, 32'h0, 32'hA5A5_1234, 1'b0, 3, "R11");
    access(1'b1, 2'b00, 1'b0, 32'h8000_0905, 32'h0000_00C3, 32'h0, 1'b0, 4, "R11");

    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "R10", "scoreboard drained", sb_q.size(), 32'd0);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule